// File: doc/BRIEF.md
# DMA Write-Request Sizer

This block is the memory-write half of a DMA channel that copies data from an external bus into local memory. Inbound 64-bit beats, each with eight byte-enable bits, arrive from an upstream FIFO and are held in a small circular buffer. A transfer is launched with a start address, an exact byte count and a burst-range selector. The block then issues a stream of memory write requests until the whole count has been moved.

Each request is sized on the spot. It is the largest power of two that the current address alignment, the bytes still owed and the burst limit all allow. A head or tail that is not a whole aligned 8-byte word goes out as a one-word request with a partial byte-enable mask. A request is only offered once the buffer holds enough unclaimed words to cover it. Once a request is accepted, its words are reserved, and the memory side then pulls them one at a time in arrival order.

Top module: `dma_wr_sizer`

## Requirements
- R1: `in_ready` is high exactly when the buffer holds fewer than 16 words. A beat is stored when `in_valid` and `in_ready` are both high in the same cycle.
- R2: When the address is 8-byte aligned and at least 8 bytes remain, `req_len` is the largest power of two, 8 or more, that meets three conditions: it divides the address, it does not exceed the remaining count, and it does not exceed the burst limit. `req_be` is 8'hFF.
- R3: When the address has a nonzero low 3 bits, or fewer than 8 bytes remain, `req_len` is 8 and n = min(8 - addr[2:0], remaining) bytes are taken. `req_be` has ones in bit positions addr[2:0] through addr[2:0]+n-1, where bit i stands for byte lane i.
- R4: The burst limit is 64 bytes when `burst_big` is 0 at start and 128 bytes when it is 1. The value is sampled only in the start cycle.
- R5: `req_valid` is high only while a transfer is active and the unreserved buffered words number at least `req_len`/8. While it waits for `req_ready`, the request holds its address, length and mask unchanged.
- R6: Each accepted request advances the address and lowers the remaining count by the bytes it took. The accepted bytes sum to exactly `byte_count`.
- R7: `done` pulses for one cycle, in the cycle after the final request is accepted. A start with a zero byte count gives `done` in the next cycle and issues no request.
- R8: A `start` that arrives while a transfer is active is ignored.
- R9: `pull_valid` is high while accepted requests still have words in the buffer. `pull_data` and `pull_be` show the oldest buffered beat, and `pull_en` removes that beat.
- R10: After reset, `in_ready` is 1 and `req_valid`, `pull_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inbound beat present |
| in_data | input | 64 | Inbound beat data |
| in_be | input | 8 | Inbound beat byte enables |
| in_ready | output | 1 | Buffer can take a beat |
| start | input | 1 | Launch a transfer |
| start_addr | input | 32 | First memory byte address |
| byte_count | input | 16 | Exact bytes to move |
| burst_big | input | 1 | Selects the 128-byte burst limit |
| req_valid | output | 1 | Memory write request offered |
| req_addr | output | 32 | Request address |
| req_len | output | 8 | Request size in bytes |
| req_be | output | 8 | Lane mask for one-word requests |
| req_ready | input | 1 | Memory side takes the request |
| pull_valid | output | 1 | A reserved word is available |
| pull_data | output | 64 | Oldest buffered word |
| pull_be | output | 8 | Byte enables of that word |
| pull_en | input | 1 | Remove the oldest word |
| done | output | 1 | Transfer complete pulse |

## Verification
The hardest state to reach from the ports is a large request held back because the buffer has too few unclaimed words. This happens while the buffer is partly filled with words that earlier requests reserved and the memory side has not yet pulled. The stimulus gets there by feeding inbound beats sparsely, pulling reserved words slowly and withholding `req_ready` for a stretch. That builds a full buffer with `in_ready` low before a 128-byte request is released. A behavioural model of queue contents, reservations, address and remaining count predicts every output on every cycle, including a restart attempt during a transfer and a burst selector that toggles after start.

// File: rtl/dws_pkg.sv
// Shared types for the DMA write-request sizer.
// Assumes 64-bit beats with one enable bit per byte lane.
package dws_pkg;
    localparam int BEAT_BYTES = 8;

    typedef struct packed {
        logic [63:0] data;
        logic [7:0]  be;
    } beat_t;
endpackage

// File: rtl/dws_buffer.sv
// Circular write buffer with a reservation count.
// Words are written whenever space exists. Words claimed by accepted
// requests are counted as reserved and may be popped; the rest are
// reported as available for new requests.
// Assumes DEPTH is a power of two.
module dws_buffer
    import dws_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  beat_t         wr_beat,
    output logic          full,
    input  logic          reserve_en,
    input  logic [CW-1:0] reserve_words,
    input  logic          pop_en,
    output beat_t         head,
    output logic [CW-1:0] avail,
    output logic          pend_nz
);
    beat_t         mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q, pend_q;
    logic          push, pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign push    = wr_en && !full;
    assign pop     = pop_en && (pend_q != '0);
    assign head    = mem[rd_ptr];
    assign avail   = cnt_q - pend_q;
    assign pend_nz = (pend_q != '0);

    // Store an incoming beat at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_beat;
    end

    // Advance pointers and track total and reserved word counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PW'(1);
            if (pop)  rd_ptr <= rd_ptr + PW'(1);
            cnt_q  <= cnt_q + CW'(push) - CW'(pop);
            pend_q <= pend_q + (reserve_en ? reserve_words : '0) - CW'(pop);
        end
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R9
    reserve_within_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= cnt_q);
endmodule

// File: rtl/dws_sizer.sv
// Picks the next memory request from address and remaining count.
// An unaligned or sub-word piece becomes one 8-byte slot with a lane
// mask. Otherwise the largest aligned power of two within both the
// count and the burst limit is chosen.
// Assumes CNT_W is at most 32 and at least 4.
module dws_sizer #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int LEN_W    = 8,
    parameter int MAX_LOG2 = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  remain,
    input  logic [LEN_W-1:0]  limit,
    output logic [LEN_W-1:0]  take,
    output logic [LEN_W-1:0]  len,
    output logic [LEN_W-1:0]  words,
    output logic [7:0]        be
);
    logic [2:0]  off;
    logic [3:0]  room, nb;
    logic        partial;
    int unsigned sz;

    assign off     = addr[2:0];
    assign room    = 4'd8 - {1'b0, off};
    assign partial = (off != 3'd0) || (remain < CNT_W'(8));

    // Select request length, bytes consumed and lane mask.
    always_comb begin
        len   = LEN_W'(8);
        take  = LEN_W'(8);
        words = LEN_W'(1);
        be    = 8'hFF;
        nb    = 4'd0;
        sz    = 0;
        if (partial) begin
            nb   = (remain < CNT_W'(room)) ? remain[3:0] : room;
            take = LEN_W'(nb);
            be   = 8'((((9'd1 << nb) - 9'd1)) << off);
        end else begin
            for (int k = 4; k <= MAX_LOG2; k++) begin
                sz = 32'd1 << k;
                if (((addr & ADDR_W'(sz - 1)) == '0) &&
                    (32'(remain) >= sz) && (32'(limit) >= sz)) begin
                    len = LEN_W'(sz);
                end
            end
            take  = len;
            words = len >> 3;
        end
    end
endmodule

// File: rtl/dma_wr_sizer.sv
// Top of the DMA write-request sizer.
// Holds the transfer state (address, remaining bytes, burst limit),
// offers a request when enough unreserved words are buffered, and
// pulses done when the count is exhausted.
// Assumes BIG_BURST <= 8 * DEPTH so every request can be buffered.
module dma_wr_sizer
    import dws_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int DEPTH     = 16,
    parameter int DEF_BURST = 64,
    parameter int BIG_BURST = 128,
    localparam int LEN_W    = $clog2(BIG_BURST) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [63:0]       in_data,
    input  logic [7:0]        in_be,
    output logic              in_ready,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              burst_big,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [7:0]        req_be,
    input  logic              req_ready,
    output logic              pull_valid,
    output logic [63:0]       pull_data,
    output logic [7:0]        pull_be,
    input  logic              pull_en,
    output logic              done
);
    localparam int MAX_LOG2 = $clog2(BIG_BURST);
    localparam int CW       = $clog2(DEPTH + 1);

    logic              active_q, done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [LEN_W-1:0]  limit_q;
    logic [LEN_W-1:0]  take, words;
    logic [CW-1:0]     avail;
    logic              full, accept;
    beat_t             head, in_beat;

    assign in_beat = '{data: in_data, be: in_be};

    dws_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (in_valid),
        .wr_beat      (in_beat),
        .full         (full),
        .reserve_en   (accept),
        .reserve_words(CW'(words)),
        .pop_en       (pull_en),
        .head         (head),
        .avail        (avail),
        .pend_nz      (pull_valid)
    );

    dws_sizer #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .LEN_W   (LEN_W),
        .MAX_LOG2(MAX_LOG2)
    ) u_size (
        .addr  (addr_q),
        .remain(remain_q),
        .limit (limit_q),
        .take  (take),
        .len   (req_len),
        .words (words),
        .be    (req_be)
    );

    assign in_ready  = !full;
    assign pull_data = head.data;
    assign pull_be   = head.be;
    assign req_addr  = addr_q;
    assign req_valid = active_q && (remain_q != '0) && (32'(avail) >= 32'(words));
    assign accept    = req_valid && req_ready;
    assign done      = done_q;

    // Launch transfers, step address and count, and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            addr_q   <= '0;
            remain_q <= '0;
            limit_q  <= LEN_W'(DEF_BURST);
        end else begin
            done_q <= 1'b0;
            if (!active_q && start) begin
                if (byte_count == '0) begin
                    done_q <= 1'b1;
                end else begin
                    active_q <= 1'b1;
                    addr_q   <= start_addr;
                    remain_q <= byte_count;
                    limit_q  <= burst_big ? LEN_W'(BIG_BURST) : LEN_W'(DEF_BURST);
                end
            end else if (accept) begin
                addr_q   <= addr_q + ADDR_W'(take);
                remain_q <= remain_q - CNT_W'(take);
                if (remain_q == CNT_W'(take)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end
        end
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
                                    $stable(req_len) && $stable(req_be));

    // R2
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len == LEN_W'(8)) ||
                      ((req_addr & ADDR_W'(req_len - 1'b1)) == '0));

    // R4
    req_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_len <= limit_q);

    // R6
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> 32'(take) <= 32'(remain_q));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active_q && (remain_q == '0));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q && !accept |=> $stable(remain_q) && $stable(addr_q));
endmodule

// File: tb/sim_dma_wr_sizer.sv
// Behavioural reference model compared with the design on every clock.
module sim_dma_wr_sizer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, start, burst_big, req_ready, pull_en;
    logic [63:0] in_data;
    logic [7:0]  in_be;
    logic [31:0] start_addr;
    logic [15:0] byte_count;
    logic        in_ready, req_valid, pull_valid, done;
    logic [31:0] req_addr;
    logic [7:0]  req_len, req_be, pull_be;
    logic [63:0] pull_data;

    int checks = 0;
    int fails  = 0;
    int in_rate = 100, pull_rate = 100, rdy_rate = 100;

    bit [71:0]   mq [$];
    int          m_pend = 0, m_rem = 0, m_lim = 64, taken = 0;
    int unsigned m_addr = 0;
    bit          m_act = 0, m_done = 0;

    always #2 clk = ~clk;

    dma_wr_sizer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_be(in_be), .in_ready(in_ready), .start(start),
        .start_addr(start_addr), .byte_count(byte_count),
        .burst_big(burst_big), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_be(req_be), .req_ready(req_ready),
        .pull_valid(pull_valid), .pull_data(pull_data), .pull_be(pull_be),
        .pull_en(pull_en), .done(done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected request shape, shrinking from the limit downwards.
    task automatic exp_req(output int take, output int len, output int be);
        int off = int'(m_addr % 8);
        be = 0;
        if (off != 0 || m_rem < 8) begin
            take = (8 - off < m_rem) ? 8 - off : m_rem;
            len  = 8;
            for (int i = off; i < off + take; i++) be |= (1 << i);
        end else begin
            len = m_lim;
            while (len > 8 && ((m_addr % len) != 0 || len > m_rem)) len = len / 2;
            take = len;
            be   = 255;
        end
    endtask

    task automatic cycle(input bit st, input int a, input int c, input bit big, input bit hold);
        int  take, len, be, words;
        bit  exp_rv, acc, pop, push;
        @(negedge clk);
        in_valid   = ($urandom % 100) < in_rate;
        in_data    = {$urandom, $urandom};
        in_be      = 8'($urandom);
        pull_en    = ($urandom % 100) < pull_rate;
        req_ready  = !hold && (($urandom % 100) < rdy_rate);
        start      = st;
        start_addr = st ? a : $urandom;
        byte_count = st ? 16'(c) : 16'($urandom);
        burst_big  = st ? big : 1'($urandom);
        #1;
        exp_req(take, len, be);
        words  = len / 8;
        exp_rv = m_act && m_rem > 0 && (mq.size() - m_pend) >= words;
        chk("R1 in_ready", in_ready, mq.size() < 16);
        chk("R5 req_valid", req_valid, exp_rv);
        if (exp_rv && req_valid) begin
            chk("R6 req_addr", req_addr, m_addr);
            chk("R2 R4 req_len", req_len, len);
            chk("R3 req_be", req_be, be);
        end
        chk("R9 pull_valid", pull_valid, m_pend > 0);
        if (m_pend > 0) begin
            chk("R9 pull_data", pull_data, mq[0][71:8]);
            chk("R9 pull_be", pull_be, mq[0][7:0]);
        end
        chk("R7 done", done, m_done);
        acc  = exp_rv && req_ready;
        pop  = pull_en && m_pend > 0;
        push = in_valid && mq.size() < 16;
        @(posedge clk);
        m_done = 0;
        if (!m_act && st) begin
            if (c == 0) m_done = 1;
            else begin
                m_act = 1; m_addr = a; m_rem = c; m_lim = big ? 128 : 64;
            end
        end else if (acc) begin
            m_addr += take; m_rem -= take; m_pend += words; taken += take;
            if (m_rem == 0) begin m_act = 0; m_done = 1; end
        end
        if (pop) begin m_pend--; void'(mq.pop_front()); end
        if (push) mq.push_back({in_data, in_be});
    endtask

    task automatic run_xfer(input int a, input int c, input bit big, input int ir,
                            input int pr, input int rr, input int hold_n, input int restart_at);
        int n = 1;
        in_rate = ir; pull_rate = pr; rdy_rate = rr; taken = 0;
        cycle(1, a, c, big, hold_n > 0);
        while (m_act && n < 4000) begin
            // R8: a second start during the transfer must change nothing
            cycle(n == restart_at, a + 64, c + 16, !big, n < hold_n);
            n++;
        end
        if (n >= 4000) begin
            fails++;
            $display("FAIL R6 transfer stalled actual=%0d expected=%0d", m_rem, 0);
        end
        chk("R6 total bytes", taken, c);
        pull_rate = 100;
        repeat (40) cycle(0, 0, 0, 0, 1'b0);
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 0; start = 0; pull_en = 0; req_ready = 0;
        burst_big = 0; start_addr = 0; byte_count = 0; in_data = 0; in_be = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk("R10 in_ready", in_ready, 1);
        chk("R10 req_valid", req_valid, 0);
        chk("R10 pull_valid", pull_valid, 0);
        chk("R10 done", done, 0);
        run_xfer(32'h0, 256, 0, 100, 100, 100, 0, 0);     // R2 64-byte bursts
        run_xfer(32'h0, 256, 1, 100, 100, 100, 0, 0);     // R4 128-byte bursts
        run_xfer(32'h13, 123, 1, 100, 100, 100, 0, 0);    // R3 head and tail
        run_xfer(32'h105, 3, 0, 100, 100, 100, 0, 0);     // R3 within one word
        run_xfer(32'h40, 0, 0, 100, 100, 100, 0, 0);      // R7 zero count
        run_xfer(32'h0, 512, 0, 100, 100, 100, 0, 5);     // R8 restart ignored
        run_xfer(32'h80, 128, 1, 100, 100, 100, 60, 0);   // R1 full buffer, R5 hold
        run_xfer(32'h2C, 200, 1, 10, 30, 50, 0, 0);       // R5 slow fill
        for (int t = 0; t < 8; t++) begin
            run_xfer(int'($urandom % 1024), 1 + int'($urandom % 300), 1'($urandom),
                     20 + int'($urandom % 80), 20 + int'($urandom % 80),
                     20 + int'($urandom % 80), 0, 3);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule